// File: doc/BRIEF.md
# SDRAM command timing gate

This block stands between the command scheduler of an SDRAM controller and the memory command bus. The scheduler presents one command at a time: activate, read, write, precharge, mode-register load or auto refresh, together with a bank number. The gate answers in the same cycle. It grants the command when every minimum interval that applies to it has run out. Otherwise it holds the command back, and the scheduler keeps presenting it until it is granted. The gate flags a command that makes no sense for the current bank state and never issues it. It also keeps a free-running refresh timer and tells the scheduler when a refresh is owed.

All minimum intervals are given as parameters in picoseconds. At elaboration they are turned into clock counts from the clock-period parameter. Each bank has its own down-counters for row-to-column delay, minimum open time, row cycle, precharge and write recovery. Two device-wide counters cover the spacing between activates and the quiet time after a mode-register load. A configuration whose clock is faster than the selected CAS latency allows (7.5 ns for latency 3, 9.5 ns for latency 2) stops elaboration with an error.

Top module: `sdram_cmd_gate`

## Requirements
- R1: Every interval parameter becomes a count of clocks, ceil(interval / clock period). The refresh interval is floor((window / rows) / clock period). With the default 20 ns clock this gives 1 clock for the row-to-column delay, the precharge time and the activate-to-activate spacing across banks, 3 for the minimum open time, 4 for the row cycle, 2 for mode-register quiet time and 390 for the refresh interval.
- R2: A read (code 1) or write (code 2) to a bank issues no earlier than the row-to-column count after the activate (code 0) of that bank.
- R3: On one bank, a precharge (code 3) issues no earlier than the open-time count after the activate. The next activate waits both for the precharge count after that precharge and for the row-cycle count after the previous activate.
- R4: Activates to two different banks are spaced by at least the activate-to-activate count.
- R5: A precharge to an open bank waits at least max(ceil(write recovery / clock period), WR_MIN_CYC) clocks after the last write to that bank. WR_MIN_CYC defaults to 2.
- R6: A mode-register load (code 4) issues only when all banks are closed with their precharge and row-cycle windows run out. No command of any kind issues during the quiet count that follows it. A load that cannot issue yet is held back and is not flagged.
- R7: refresh_due rises every refresh-interval clocks, counted freely from reset release. Once high it stays high until an auto refresh is granted, and it is low in the cycle after that grant.
- R8: An auto refresh (code 5) issues only when all banks are closed with their precharge and row-cycle windows run out. A refresh requested while a bank is open is held back and is not flagged. After a refresh, each bank waits the row-cycle count before its next activate.
- R9: A read or write to a closed bank, an activate to an open bank, and the codes 6 and 7 raise proto_err together with req_valid. Such a request is not issued and leaves the bank state unchanged.
- R10: cmd_fire equals req_valid AND req_ready in the same cycle, and the windows start at that clock edge. After reset all banks are closed, no window is pending, refresh_due is low and an activate is ready at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A command is presented |
| req_cmd | input | 3 | Command code: 0 activate, 1 read, 2 write, 3 precharge, 4 mode-register load, 5 auto refresh |
| req_bank | input | $clog2(BANKS) | Target bank |
| cmd_fire | output | 1 | Command issued at this edge |
| req_ready | output | 1 | The presented command meets all its windows and is legal |
| proto_err | output | 1 | The presented command is illegal for the bank state |
| refresh_due | output | 1 | A refresh is owed |

## Verification
The hardest case to reach is a command limited by two windows at once, so that only the longer one decides when it issues. Examples are a precharge that follows a write that came soon after an activate, and an activate that follows both a precharge and a still-running row cycle. The bench sweeps command chains of several shapes over every bank and every ordered bank pair. It presents each command as soon as the previous one is granted and compares the grant edge with the maximum of the windows, computed from the issue times it has logged itself. Refresh timing is checked over two whole periods, with a refresh granted between them after banks have been open and closed.

// File: rtl/sdram_cmd_gate.sv
module sdram_cmd_gate #(
  parameter int CLK_PS        = 20000,
  parameter int CAS_LAT       = 3,
  parameter int MIN_PS_CL3    = 7500,
  parameter int MIN_PS_CL2    = 9500,
  parameter int BANKS         = 4,
  parameter int T_RCD_PS      = 19000,
  parameter int T_RP_PS       = 19000,
  parameter int T_RAS_PS      = 45000,
  parameter int T_RC_PS       = 67000,
  parameter int T_RRD_PS      = 15000,
  parameter int T_WR_PS       = 14000,
  parameter int WR_MIN_CYC    = 2,
  parameter int MRD_CYC       = 2,
  parameter int REF_WINDOW_US = 64000,
  parameter int REF_ROWS      = 8192,
  localparam int BW = $clog2(BANKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_cmd,
  input  logic [BW-1:0] req_bank,
  output logic          cmd_fire,
  output logic          req_ready,
  output logic          proto_err,
  output logic          refresh_due
);

  function automatic int cyc_of(input int ps);
    return (ps + CLK_PS - 1) / CLK_PS;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RCD_C  = cyc_of(T_RCD_PS);
  localparam int RP_C   = cyc_of(T_RP_PS);
  localparam int RAS_C  = cyc_of(T_RAS_PS);
  localparam int RC_C   = cyc_of(T_RC_PS);
  localparam int RRD_C  = cyc_of(T_RRD_PS);
  localparam int WR_C   = imax(cyc_of(T_WR_PS), WR_MIN_CYC);
  localparam int MRD_C  = imax(MRD_CYC, 1);
  localparam longint REF_PS = (longint'(REF_WINDOW_US) * 64'd1000000) / longint'(REF_ROWS);
  localparam int REF_C  = imax(int'(REF_PS / longint'(CLK_PS)), 2);
  localparam int MAXC   = imax(imax(imax(RCD_C, RP_C), imax(RAS_C, RC_C)),
                               imax(imax(RRD_C, WR_C), MRD_C));
  localparam int CW     = $clog2(MAXC + 1);
  localparam int RW     = $clog2(REF_C + 1);
  localparam bit CLK_OK = (CAS_LAT == 3) ? (CLK_PS >= MIN_PS_CL3) :
                          (CAS_LAT == 2) ? (CLK_PS >= MIN_PS_CL2) : 1'b0;

  if (!CLK_OK) begin : g_bad_clock
    $error("clock period too short for the selected CAS latency");
  end

  typedef enum logic [2:0] {
    CMD_ACT = 3'd0, CMD_RD = 3'd1, CMD_WR = 3'd2,
    CMD_PRE = 3'd3, CMD_MRS = 3'd4, CMD_REF = 3'd5
  } cmd_e;

  function automatic logic [CW-1:0] dn(input logic [CW-1:0] v);
    return (v == '0) ? v : v - CW'(1);
  endfunction

  logic [BANKS-1:0] open_q;
  logic [CW-1:0]    rcd_q [BANKS];
  logic [CW-1:0]    ras_q [BANKS];
  logic [CW-1:0]    rc_q  [BANKS];
  logic [CW-1:0]    rp_q  [BANKS];
  logic [CW-1:0]    wr_q  [BANKS];
  logic [CW-1:0]    rrd_q, mrd_q;
  logic [RW-1:0]    ref_cnt;
  logic             timing_ok, illegal, banks_quiet;

  always_comb begin
    banks_quiet = 1'b1;
    for (int b = 0; b < BANKS; b++)
      if (open_q[b] || rp_q[b] != '0 || rc_q[b] != '0) banks_quiet = 1'b0;
  end

  always_comb begin
    timing_ok = 1'b0;
    illegal   = 1'b0;
    case (req_cmd)
      CMD_ACT: begin
        illegal   = open_q[req_bank];
        timing_ok = rp_q[req_bank] == '0 && rc_q[req_bank] == '0 && rrd_q == '0;
      end
      CMD_RD, CMD_WR: begin
        illegal   = !open_q[req_bank];
        timing_ok = rcd_q[req_bank] == '0;
      end
      CMD_PRE: timing_ok = !open_q[req_bank] ||
                           (ras_q[req_bank] == '0 && wr_q[req_bank] == '0);
      CMD_MRS, CMD_REF: timing_ok = banks_quiet;
      default: illegal = 1'b1;
    endcase
    if (mrd_q != '0) timing_ok = 1'b0;
  end

  assign req_ready = timing_ok && !illegal;
  assign cmd_fire  = req_valid && req_ready;
  assign proto_err = req_valid && illegal;

  wire fire_act = cmd_fire && req_cmd == CMD_ACT;
  wire fire_mrs = cmd_fire && req_cmd == CMD_MRS;
  wire fire_ref = cmd_fire && req_cmd == CMD_REF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= '0;
      for (int b = 0; b < BANKS; b++) begin
        rcd_q[b] <= '0;
        ras_q[b] <= '0;
        rc_q[b]  <= '0;
        rp_q[b]  <= '0;
        wr_q[b]  <= '0;
      end
    end else begin
      for (int b = 0; b < BANKS; b++) begin
        rcd_q[b] <= dn(rcd_q[b]);
        ras_q[b] <= dn(ras_q[b]);
        rc_q[b]  <= dn(rc_q[b]);
        rp_q[b]  <= dn(rp_q[b]);
        wr_q[b]  <= dn(wr_q[b]);
        if (cmd_fire && req_bank == BW'(b)) begin
          case (req_cmd)
            CMD_ACT: begin
              open_q[b] <= 1'b1;
              rcd_q[b]  <= CW'(RCD_C - 1);
              ras_q[b]  <= CW'(RAS_C - 1);
              rc_q[b]   <= CW'(RC_C - 1);
            end
            CMD_WR:  wr_q[b] <= CW'(WR_C - 1);
            CMD_PRE: if (open_q[b]) begin
              open_q[b] <= 1'b0;
              rp_q[b]   <= CW'(RP_C - 1);
            end
            default: ;
          endcase
        end
        if (fire_ref) rc_q[b] <= CW'(RC_C - 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rrd_q <= '0;
      mrd_q <= '0;
    end else begin
      rrd_q <= fire_act ? CW'(RRD_C - 1) : dn(rrd_q);
      mrd_q <= fire_mrs ? CW'(MRD_C - 1) : dn(mrd_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt     <= '0;
      refresh_due <= 1'b0;
    end else if (ref_cnt == RW'(REF_C - 1)) begin
      ref_cnt     <= '0;
      refresh_due <= 1'b1;
    end else begin
      ref_cnt     <= ref_cnt + RW'(1);
      if (fire_ref) refresh_due <= 1'b0;
    end
  end

endmodule

module sdram_cmd_gate_chk #(
  parameter int BANKS = 4,
  parameter int BW    = 2,
  parameter int WR_C  = 2,
  parameter int MRD_C = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [2:0]       req_cmd,
  input logic [BW-1:0]    req_bank,
  input logic             cmd_fire,
  input logic             req_ready,
  input logic             proto_err,
  input logic             refresh_due,
  input logic [BANKS-1:0] open_q
);

  p_fire_handshake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |-> (req_valid && req_ready));

  p_err_not_issued_r9: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> !cmd_fire);

  p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && req_cmd == 3'd0) |=> open_q[$past(req_bank)]);

  p_pre_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && req_cmd == 3'd3) |=> !open_q[$past(req_bank)]);

  p_wr_recovery_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (WR_C > 1 && cmd_fire && req_cmd == 3'd2) |=>
      !(cmd_fire && req_cmd == 3'd3 && req_bank == $past(req_bank)));

  p_mrs_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (MRD_C > 1 && cmd_fire && req_cmd == 3'd4) |=> !cmd_fire);

  p_due_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_due && !(cmd_fire && req_cmd == 3'd5)) |=> refresh_due);

  p_ref_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && req_cmd == 3'd5) |-> open_q == '0);

endmodule

bind sdram_cmd_gate sdram_cmd_gate_chk #(
  .BANKS(BANKS), .BW(BW), .WR_C(WR_C), .MRD_C(MRD_C)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
  .req_bank(req_bank), .cmd_fire(cmd_fire), .req_ready(req_ready),
  .proto_err(proto_err), .refresh_due(refresh_due), .open_q(open_q)
);

// File: tb/tb_sdram_cmd_gate.sv
module tb_sdram_cmd_gate;
  localparam int TCK  = 20000;
  localparam int RCD  = (19000 + TCK - 1) / TCK;
  localparam int RP   = (19000 + TCK - 1) / TCK;
  localparam int RAS  = (45000 + TCK - 1) / TCK;
  localparam int RC   = (67000 + TCK - 1) / TCK;
  localparam int RRD  = (15000 + TCK - 1) / TCK;
  localparam int WRX  = (14000 + TCK - 1) / TCK;
  localparam int WR   = (WRX > 2) ? WRX : 2;
  localparam int MRD  = 2;
  localparam int REFC = 7812500 / TCK;

  logic       clk = 0, rst_n = 0, req_valid = 0;
  logic [2:0] req_cmd = 0;
  logic [1:0] req_bank = 0;
  wire        cmd_fire, req_ready, proto_err, refresh_due;

  sdram_cmd_gate #(.CLK_PS(TCK)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_bank(req_bank), .cmd_fire(cmd_fire), .req_ready(req_ready),
    .proto_err(proto_err), .refresh_due(refresh_due)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc = rst_n ? cyc + 1 : 0;

  int total = 0, bad = 0;
  bit finished = 0;

  int act_t[4], pre_t[4], wr_t[4];
  bit opn[4];
  int last_act = -100, mrs_t = -100;

  int rise_t[4];
  int nrise = 0;
  bit prev_due = 0;
  always @(negedge clk) begin
    if (rst_n && refresh_due && !prev_due && nrise < 4) begin
      rise_t[nrise] = cyc;
      nrise++;
    end
    prev_due = refresh_due;
  end

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int earliest(input int c, input int b, input int start);
    int e;
    e = mx(start, mrs_t + MRD);
    case (c)
      0: e = mx(e, mx(mx(act_t[b] + RC, pre_t[b] + RP), last_act + RRD));
      1, 2: e = mx(e, act_t[b] + RCD);
      3: if (opn[b]) e = mx(e, mx(act_t[b] + RAS, wr_t[b] + WR));
      default: for (int i = 0; i < 4; i++)
        e = mx(e, mx(pre_t[i] + RP, act_t[i] + RC));
    endcase
    return e;
  endfunction

  int last_issue = 0;

  task automatic go(input int c, input int b, input string req);
    int start, exp, n, t;
    @(negedge clk);
    req_cmd = 3'(c); req_bank = 2'(b); req_valid = 1;
    start = cyc + 1;
    exp = earliest(c, b, start);
    #1; n = 0;
    while (!req_ready && n < 100) begin
      @(negedge clk); #1; n++;
    end
    if (n >= 100) begin
      req_valid = 0;
      chk(0, req, $sformatf("cmd %0d bank %0d never granted", c, b), cyc, exp);
      return;
    end
    @(posedge clk); #1;
    t = cyc;
    req_valid = 0;
    chk(t == exp, req, $sformatf("issue edge of cmd %0d bank %0d", c, b), t, exp);
    last_issue = t;
    case (c)
      0: begin act_t[b] = t; opn[b] = 1; last_act = t; end
      2: wr_t[b] = t;
      3: if (opn[b]) begin pre_t[b] = t; opn[b] = 0; end
      4: mrs_t = t;
      5: for (int i = 0; i < 4; i++) act_t[i] = t;
      default: ;
    endcase
  endtask

  task automatic peek(input int c, input int b, input bit er, input bit ee,
                      input string req);
    @(negedge clk);
    req_cmd = 3'(c); req_bank = 2'(b); req_valid = 1;
    #1;
    chk(req_ready == er, req, $sformatf("ready for cmd %0d bank %0d", c, b), req_ready, er);
    chk(proto_err == ee, req, $sformatf("error for cmd %0d bank %0d", c, b), proto_err, ee);
    chk(cmd_fire == (er && !ee), req, "fire equals valid and ready", cmd_fire, er && !ee);
    #5 req_valid = 0;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      act_t[i] = -100; pre_t[i] = -100; wr_t[i] = -100; opn[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(refresh_due == 0, "R10", "refresh_due after reset", refresh_due, 0);
    chk(proto_err == 0, "R10", "proto_err after reset", proto_err, 0);
    peek(0, 0, 1, 0, "R10");

    for (int b = 0; b < 4; b++) begin
      go(0, b, "R2"); go(1, b, "R2"); go(2, b, "R2"); go(3, b, "R5");
    end
    for (int b = 0; b < 4; b++) begin
      go(0, b, "R2"); go(2, b, "R2"); go(3, b, "R5");
    end
    for (int b = 0; b < 4; b++) begin
      go(0, b, "R3"); go(3, b, "R3"); go(0, b, "R3"); go(3, b, "R3");
    end
    for (int a = 0; a < 4; a++)
      for (int c = 0; c < 4; c++)
        if (a != c) begin
          go(0, a, "R4"); go(0, c, "R4"); go(3, a, "R3"); go(3, c, "R3");
        end

    peek(1, 2, 0, 1, "R9");
    peek(2, 3, 0, 1, "R9");
    peek(6, 0, 0, 1, "R9");
    peek(7, 1, 0, 1, "R9");
    peek(0, 2, 1, 0, "R9");
    go(0, 0, "R3");
    peek(0, 0, 0, 1, "R9");
    peek(1, 0, 1, 0, "R9");
    peek(5, 1, 0, 0, "R8");
    peek(4, 1, 0, 0, "R6");
    go(3, 0, "R3");

    go(4, 0, "R6");
    go(0, 1, "R6");
    go(3, 1, "R3");
    go(4, 0, "R6");
    go(3, 2, "R6");
    go(4, 0, "R6");

    while (nrise < 1 && cyc < 2000) @(negedge clk);
    chk(nrise >= 1 && rise_t[0] == REFC, "R7", "first refresh_due rise edge",
        rise_t[0], REFC);
    #1;
    chk(refresh_due == 1, "R7", "refresh_due held before refresh", refresh_due, 1);
    go(5, 0, "R8");
    @(negedge clk); #1;
    chk(refresh_due == 0, "R7", "refresh_due cleared after refresh", refresh_due, 0);
    go(0, 0, "R8");
    go(3, 0, "R3");
    go(0, 3, "R8");
    go(3, 3, "R3");
    while (nrise < 2 && cyc < 3000) @(negedge clk);
    chk(nrise >= 2 && rise_t[1] == 2 * REFC, "R1", "second refresh_due rise edge",
        rise_t[1], 2 * REFC);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20 * 1ns);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R10 watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule